// File: doc/BRIEF.md
# VS-level interrupt delegation and enable register file

This block holds the hypervisor's per-hart state for interrupts aimed at a virtual supervisor guest. Four hypervisor registers live here: delegation, enable, virtual-pending and pending. A fifth register, the guest's enable view, keeps no storage of its own. It is an alias built from the hypervisor enable bits, shifted down by one position and gated per bit by delegation.

The pending register combines the bits software wrote into virtual-pending with live hardware lines. The hardware lines are a guest external summary bit, the guest line chosen by the guest-select logic outside this block, and other VS-level external and timer sources. The combined vector also drives a dedicated output for the interrupt selection logic, which lies outside this block.

Accesses arrive on a plain CSR port. The port takes a 12-bit address, a write strobe and write data, and returns combinational read data. There is no back-pressure: the block accepts an access in every cycle, and a write takes effect at the next rising clock edge. While the virtualisation flag is high, the guest view is also reachable at address 0x144.

Top module: `vs_irq_csr`

## Requirements
- R1: After reset, every mapped register reads zero, and with all hardware lines low the pending output is zero.
- R2: Delegation (address 0x603) stores bits 2, 6, 10 and 13. Every other bit reads zero, including bits 1, 5, 9 and 12.
- R3: Enable (address 0x604) stores bits 2, 6, 10 and 12. Every other bit reads zero.
- R4: Virtual-pending (address 0x645) stores bits 2, 6 and 10. Every other bit reads zero.
- R5: Pending (address 0x608) is built as follows, and the pending output equals its read value:
  - bit 12 is the guest external summary input;
  - bit 10 is virtual-pending bit 10 OR the selected guest line OR the other external source;
  - bit 6 is virtual-pending bit 6 OR the timer source;
  - bit 2 is virtual-pending bit 2;
  - all other bits read zero.
- R6: A write to pending changes only virtual-pending bit 2, which takes write-data bit 2. Bits 6 and 10 keep their values.
- R7: The guest view (address 0x204) reads as follows:
  - bits 1, 5 and 9 show enable bits 2, 6 and 10, each forced to zero while delegation bit 2, 6 or 10 respectively is clear;
  - bit 13 shows the counter-overflow enable input AND delegation bit 13;
  - all other bits read zero.
- R8: A write to the guest view copies write-data bit 1, 5 or 9 into enable bit 2, 6 or 10 only where the matching delegation bit is set. Elsewhere the write is dropped, and enable bit 12 is never touched.
- R9: Address 0x144 behaves as the guest view only while the virtualisation flag is high. Otherwise it reads zero and ignores writes, like every unmapped address.
- R10: Read data is combinational. A write is not visible during its own cycle and is visible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr_i | input | 12 | CSR address |
| csr_we_i | input | 1 | Write strobe |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Combinational read data |
| virt_mode_i | input | 1 | Virtualisation mode active |
| gext_sum_i | input | 1 | Guest external summary bit from the collector |
| gext_sel_i | input | 1 | Selected guest external line |
| vs_ext_i | input | 1 | Other VS-level external source |
| vs_tmr_i | input | 1 | VS-level timer source |
| ovf_en_i | input | 1 | Supervisor counter-overflow enable bit |
| pend_o | output | XLEN | Pending vector |

## Verification
The hold and drop properties assume that the address, write strobe and write data are stable and known around each rising edge, and that the hardware lines never carry X. The bench satisfies this by changing every input on the falling edge and sampling results one nanosecond later. It also keeps each write strobe to exactly one cycle, so every write lands on a single known edge.

// File: rtl/vsirq_pkg.sv
package vsirq_pkg;
  localparam logic [11:0] ADR_DELEG  = 12'h603;
  localparam logic [11:0] ADR_HEN    = 12'h604;
  localparam logic [11:0] ADR_HPEND  = 12'h608;
  localparam logic [11:0] ADR_VPEND  = 12'h645;
  localparam logic [11:0] ADR_GVIEW  = 12'h204;
  localparam logic [11:0] ADR_GVIRT  = 12'h144;

  localparam int NVS    = 3;   // software, timer, external VS lines
  localparam int BIT_GX = 12;  // guest external summary position
  localparam int BIT_OV = 13;  // counter-overflow view position

  // position of VS line i in hypervisor registers (2, 6, 10)
  function automatic int vs_pos(input int i);
    return 2 + 4 * i;
  endfunction

  typedef struct packed {
    logic deleg;
    logic hen;
    logic hpend;
    logic vpend;
    logic gview;
  } sel_t;
endpackage

// File: rtl/vsirq_decode.sv
module vsirq_decode
  import vsirq_pkg::*;
(
  input  logic [11:0] addr_i,
  input  logic        we_i,
  input  logic        virt_i,
  output sel_t        rsel_o,
  output sel_t        wsel_o
);
  always_comb begin
    rsel_o       = '0;
    rsel_o.deleg = (addr_i == ADR_DELEG);
    rsel_o.hen   = (addr_i == ADR_HEN);
    rsel_o.hpend = (addr_i == ADR_HPEND);
    rsel_o.vpend = (addr_i == ADR_VPEND);
    rsel_o.gview = (addr_i == ADR_GVIEW) || (virt_i && addr_i == ADR_GVIRT);
  end

  assign wsel_o = we_i ? rsel_o : '0;
endmodule

// File: rtl/vsirq_deleg.sv
module vsirq_deleg
  import vsirq_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] deleg_o
);
  logic [NVS-1:0] vs_q;
  logic           ov_q;
  logic           unused_wbits;

  assign unused_wbits = ^wdata_i;

  for (genvar i = 0; i < NVS; i++) begin : g_vs
    localparam int P = vs_pos(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    vs_q[i] <= 1'b0;
      else if (wr_i) vs_q[i] <= wdata_i[P];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ov_q <= 1'b0;
    else if (wr_i) ov_q <= wdata_i[BIT_OV];
  end

  always_comb begin
    deleg_o = '0;
    for (int i = 0; i < NVS; i++) deleg_o[vs_pos(i)] = vs_q[i];
    deleg_o[BIT_OV] = ov_q;
  end

  AST_DELEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(deleg_o)); // R2
endmodule

// File: rtl/vsirq_enable.sv
module vsirq_enable
  import vsirq_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hen_wr_i,
  input  logic            gv_wr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] deleg_i,
  input  logic            ovf_en_i,
  output logic [XLEN-1:0] hen_o,
  output logic [XLEN-1:0] gview_o
);
  logic [NVS-1:0] en_q;
  logic           gx_q;
  logic           unused_bits;

  assign unused_bits = ^{wdata_i, deleg_i};

  for (genvar i = 0; i < NVS; i++) begin : g_en
    localparam int P = vs_pos(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      en_q[i] <= 1'b0;
      else if (hen_wr_i)               en_q[i] <= wdata_i[P];
      else if (gv_wr_i && deleg_i[P])  en_q[i] <= wdata_i[P-1];
    end

    AST_GV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (gv_wr_i && !deleg_i[P]) |=> $stable(en_q[i])); // R8
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gx_q <= 1'b0;
    else if (hen_wr_i) gx_q <= wdata_i[BIT_GX];
  end

  always_comb begin
    hen_o   = '0;
    gview_o = '0;
    for (int i = 0; i < NVS; i++) begin
      hen_o[vs_pos(i)]     = en_q[i];
      gview_o[vs_pos(i)-1] = en_q[i] & deleg_i[vs_pos(i)];
    end
    hen_o[BIT_GX]   = gx_q;
    gview_o[BIT_OV] = ovf_en_i & deleg_i[BIT_OV];
  end

  AST_HEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hen_wr_i && !gv_wr_i) |=> $stable(hen_o)); // R3
  AST_GX_GUEST: assert property (@(posedge clk) disable iff (!rst_n)
    !hen_wr_i |=> $stable(gx_q)); // R8
endmodule

// File: rtl/vsirq_pending.sv
module vsirq_pending
  import vsirq_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vp_wr_i,
  input  logic            hp_wr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            gext_sum_i,
  input  logic            gext_sel_i,
  input  logic            vs_ext_i,
  input  logic            vs_tmr_i,
  output logic [XLEN-1:0] vpend_o,
  output logic [XLEN-1:0] pend_o
);
  logic [NVS-1:0] vp_q;
  logic           unused_wbits;

  assign unused_wbits = ^wdata_i;

  for (genvar i = 0; i < NVS; i++) begin : g_vp
    localparam int P = vs_pos(i);
    if (i == 0) begin : g_sw
      // software line also writable through the pending address
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   vp_q[i] <= 1'b0;
        else if (vp_wr_i || hp_wr_i)  vp_q[i] <= wdata_i[P];
      end
    end else begin : g_hw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       vp_q[i] <= 1'b0;
        else if (vp_wr_i) vp_q[i] <= wdata_i[P];
      end
    end
  end

  always_comb begin
    vpend_o = '0;
    for (int i = 0; i < NVS; i++) vpend_o[vs_pos(i)] = vp_q[i];
  end

  always_comb begin
    pend_o            = '0;
    pend_o[vs_pos(0)] = vp_q[0];
    pend_o[vs_pos(1)] = vp_q[1] | vs_tmr_i;
    pend_o[vs_pos(2)] = vp_q[2] | gext_sel_i | vs_ext_i;
    pend_o[BIT_GX]    = gext_sum_i;
  end

  AST_HPEND_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_wr_i && !vp_wr_i) |=> $stable(vp_q[NVS-1:1])); // R6
  AST_VP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!vp_wr_i && !hp_wr_i) |=> $stable(vpend_o)); // R4
  AST_TMR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    vs_tmr_i |-> pend_o[vs_pos(1)]); // R5
endmodule

// File: rtl/vs_irq_csr.sv
module vs_irq_csr
  import vsirq_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csr_addr_i,
  input  logic            csr_we_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  input  logic            virt_mode_i,
  input  logic            gext_sum_i,
  input  logic            gext_sel_i,
  input  logic            vs_ext_i,
  input  logic            vs_tmr_i,
  input  logic            ovf_en_i,
  output logic [XLEN-1:0] pend_o
);
  sel_t            rsel, wsel;
  logic [XLEN-1:0] deleg, hen, gview, vpend, pend;

  vsirq_decode u_dec (
    .addr_i (csr_addr_i),
    .we_i   (csr_we_i),
    .virt_i (virt_mode_i),
    .rsel_o (rsel),
    .wsel_o (wsel)
  );

  vsirq_deleg #(.XLEN(XLEN)) u_deleg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wsel.deleg),
    .wdata_i (csr_wdata_i),
    .deleg_o (deleg)
  );

  vsirq_enable #(.XLEN(XLEN)) u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .hen_wr_i (wsel.hen),
    .gv_wr_i  (wsel.gview),
    .wdata_i  (csr_wdata_i),
    .deleg_i  (deleg),
    .ovf_en_i (ovf_en_i),
    .hen_o    (hen),
    .gview_o  (gview)
  );

  vsirq_pending #(.XLEN(XLEN)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .vp_wr_i    (wsel.vpend),
    .hp_wr_i    (wsel.hpend),
    .wdata_i    (csr_wdata_i),
    .gext_sum_i (gext_sum_i),
    .gext_sel_i (gext_sel_i),
    .vs_ext_i   (vs_ext_i),
    .vs_tmr_i   (vs_tmr_i),
    .vpend_o    (vpend),
    .pend_o     (pend)
  );

  always_comb begin
    csr_rdata_o = '0;
    unique case (1'b1)
      rsel.deleg: csr_rdata_o = deleg;
      rsel.hen:   csr_rdata_o = hen;
      rsel.hpend: csr_rdata_o = pend;
      rsel.vpend: csr_rdata_o = vpend;
      rsel.gview: csr_rdata_o = gview;
      default:    csr_rdata_o = '0;
    endcase
  end

  assign pend_o = pend;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsel == '0) |-> (csr_rdata_o == '0)); // R9
  AST_VIRT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!virt_mode_i && csr_addr_i == ADR_GVIRT) |-> (csr_rdata_o == '0)); // R9
  AST_PEND_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    rsel.hpend |-> (csr_rdata_o == pend_o)); // R5
  AST_GV_DELEG: assert property (@(posedge clk) disable iff (!rst_n)
    (rsel.gview && !deleg[vs_pos(0)]) |-> !csr_rdata_o[vs_pos(0)-1]); // R7
endmodule

// File: tb/tb_vs_irq_csr.sv
module tb_vs_irq_csr;
  localparam int XLEN = 64;
  localparam logic [63:0] M_DELEG = 64'h2444;  // bits 2,6,10,13
  localparam logic [63:0] M_HEN   = 64'h1444;  // bits 2,6,10,12
  localparam logic [63:0] M_VP    = 64'h0444;  // bits 2,6,10
  localparam logic [63:0] M_GV    = 64'h0222;  // bits 1,5,9

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [11:0]     addr = '0;
  logic            we = 1'b0;
  logic [XLEN-1:0] wdata = '0;
  logic [XLEN-1:0] rdata;
  logic            virt = 1'b0, gsum = 1'b0, gsel = 1'b0, vext = 1'b0, vtmr = 1'b0, ovf = 1'b0;
  logic [XLEN-1:0] pend;
  int              checks = 0, failures = 0;
  bit              done = 1'b0;

  always #4 clk = ~clk;

  vs_irq_csr #(.XLEN(XLEN)) dut (
    .clk(clk), .rst_n(rst_n), .csr_addr_i(addr), .csr_we_i(we),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .virt_mode_i(virt),
    .gext_sum_i(gsum), .gext_sel_i(gsel), .vs_ext_i(vext), .vs_tmr_i(vtmr),
    .ovf_en_i(ovf), .pend_o(pend)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [63:0] spread4(input logic [3:0] v, input int top);
    return (64'(v[0]) << 2) | (64'(v[1]) << 6) | (64'(v[2]) << 10) | (64'(v[3]) << top);
  endfunction

  function automatic logic [63:0] gv_exp(input logic [63:0] d, input logic [63:0] e, input logic o);
    return (((e & d) >> 1) & M_GV) | (64'(o & d[13]) << 13);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] r, d, e, w, pre, exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(12'h603, r); chk("R1 deleg", r, 0);
    rd(12'h604, r); chk("R1 hen", r, 0);
    rd(12'h608, r); chk("R1 hpend", r, 0);
    rd(12'h645, r); chk("R1 vpend", r, 0);
    rd(12'h204, r); chk("R1 gview", r, 0);
    chk("R1 pend_o", pend, 0);

    // R2 R3 R4: walking one over every bit position
    for (int k = 0; k < 64; k++) begin
      w = 64'(1) << k;
      wr(12'h603, w); rd(12'h603, r); chk("R2 deleg bit", r, w & M_DELEG);
      wr(12'h604, w); rd(12'h604, r); chk("R3 hen bit", r, w & M_HEN);
      wr(12'h645, w); rd(12'h645, r); chk("R4 vpend bit", r, w & M_VP);
    end
    wr(12'h603, '1); rd(12'h603, r); chk("R2 all ones", r, M_DELEG);
    wr(12'h604, '1); rd(12'h604, r); chk("R3 all ones", r, M_HEN);
    wr(12'h645, '1); rd(12'h645, r); chk("R4 all ones", r, M_VP);
    wr(12'h645, 0);

    // R7: guest view read over every delegation/enable/overflow combination
    for (int dd = 0; dd < 16; dd++)
      for (int ee = 0; ee < 16; ee++)
        for (int oo = 0; oo < 2; oo++) begin
          d = spread4(4'(dd), 13);
          e = spread4(4'(ee), 12);
          wr(12'h603, d | ~M_DELEG);
          wr(12'h604, e | ~M_HEN);
          ovf = oo[0];
          rd(12'h204, r); chk("R7 gview", r, gv_exp(d, e, oo[0]));
        end
    ovf = 1'b0;

    // R8: guest view write gated per bit by delegation
    for (int p = 0; p < 2; p++)
      for (int dd = 0; dd < 16; dd++)
        for (int ww = 0; ww < 8; ww++) begin
          d = spread4(4'(dd), 13);
          pre = (p == 0) ? 64'h0 : M_HEN;
          wr(12'h603, d);
          wr(12'h604, pre);
          w = ~M_GV | (64'(ww[0]) << 1) | (64'(ww[1]) << 5) | (64'(ww[2]) << 9);
          wr(12'h204, w);
          exp = pre;
          for (int i = 0; i < 3; i++)
            if (d[2+4*i]) exp[2+4*i] = w[1+4*i];
          rd(12'h604, r); chk("R8 hen after guest write", r, exp);
        end

    // R9: virtual address gating and unmapped addresses
    wr(12'h603, M_DELEG);
    wr(12'h604, 64'h0444);
    virt = 1'b0;
    rd(12'h144, r); chk("R9 virt off read", r, 0);
    wr(12'h144, 0);
    rd(12'h604, r); chk("R9 virt off write ignored", r, 64'h0444);
    virt = 1'b1;
    rd(12'h144, r); chk("R9 virt on read", r, 64'h0222);
    wr(12'h144, 64'h0020);
    rd(12'h604, r); chk("R9 virt on write", r, 64'h0040);
    rd(12'h104, r); chk("R9 unmapped 104", r, 0);
    rd(12'h000, r); chk("R9 unmapped 000", r, 0);
    wr(12'h646, '1);
    rd(12'h645, r); chk("R9 unmapped write", r, 0);
    virt = 1'b0;

    // R5: pending composition over every source combination
    for (int vv = 0; vv < 8; vv++)
      for (int ss = 0; ss < 16; ss++) begin
        w = (64'(vv[0]) << 2) | (64'(vv[1]) << 6) | (64'(vv[2]) << 10);
        wr(12'h645, w);
        gsum = ss[0]; gsel = ss[1]; vext = ss[2]; vtmr = ss[3];
        exp = (64'(vv[0]) << 2) | (64'(vv[1] | ss[3]) << 6) |
              (64'(vv[2] | ss[1] | ss[2]) << 10) | (64'(ss[0]) << 12);
        rd(12'h608, r); chk("R5 hpend read", r, exp);
        chk("R5 pend_o", pend, exp);
      end
    gsum = 1'b0; gsel = 1'b0; vext = 1'b0; vtmr = 1'b0;

    // R6: writes at the pending address reach only bit 2
    wr(12'h645, 0);
    wr(12'h608, '1);
    rd(12'h645, r); chk("R6 set only bit2", r, 64'h0004);
    wr(12'h645, M_VP);
    wr(12'h608, 0);
    rd(12'h645, r); chk("R6 clear only bit2", r, 64'h0440);

    // R10: write invisible in its own cycle, visible in the next
    wr(12'h604, 0);
    @(negedge clk);
    addr = 12'h604; we = 1'b1; wdata = M_HEN;
    #1; chk("R10 same cycle old", rdata, 0);
    @(negedge clk);
    we = 1'b0;
    #1; chk("R10 next cycle new", rdata, M_HEN);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule